// File: doc/BRIEF.md
# Timebase Interval Timer

This block measures a single interval on a tick input and tells an interrupt controller when that interval has run out. Software sets it up through one 8-bit control register. The register picks one of four interval lengths, enables or masks the interrupt, restarts the count, and exposes an overflow flag that the hardware sets.

The timer is one-shot. A restart loads the counter with the selected interval. Each cycle with `tick_en` high takes one from the count. On the last tick the overflow flag is set, the counter stops, and a one-cycle `irq_set` pulse goes to the interrupt controller if interrupts are enabled. The timer does not count again until the next restart. A restart also withdraws any pending request, and so does a software clear of the overflow flag. Both cases produce a one-cycle `irq_clr` pulse. The prescaler that produces `tick_en` lives outside this block.

Top module: `tbt_timer`

## Requirements
- R1: After reset the register reads 8'h00, the counter is stopped, and neither `irq_set` nor `irq_clr` pulses until software writes the register.
- R2: A read returns the last written value in bits 7:4 and 2:0, and the hardware overflow flag in bit 3.
- R3: Rate field bits 1:0 set the interval to 1, 4, 16 or 128 times `BASE_TICKS` ticks, for codes 0 to 3. The overflow flag and `irq_set` appear on the clock edge that consumes the last tick.
- R4: Only cycles with `tick_en` high advance the counter.
- R5: A write with bit 2 (restart, active low) at 0 reloads the counter and pulses `irq_clr` for one cycle.
- R6: A write that changes the rate field reloads the counter even when bit 2 is 1. It does not pulse `irq_clr` unless R5 or R10 applies.
- R7: A write with bit 2 at 1 and an unchanged rate field leaves a running count undisturbed.
- R8: When the interval expires, the counter stops. No further `irq_set` occurs until the next reload.
- R9: Expiry always sets the overflow flag. `irq_set` pulses only if the enable bit (bit 4) was 1 when the interval expired.
- R10: Writing 0 to bit 3 while the flag is 1 clears the flag and pulses `irq_clr`. Writing 1 to bit 3 never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one tick per cycle when high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| irq_set | output | 1 | One-cycle request to raise the interrupt |
| irq_clr | output | 1 | One-cycle request to withdraw the interrupt |

## Verification
The embedded assertions check the following on every cycle:
- Each `irq_set` comes with a set flag and a previously set enable bit.
- The counter is stopped once the flag rises.
- A stopped counter never raises a request.
- A restart or rate-change write always leaves the counter running.
- Software can never set the flag.

Only the bench scenarios can show the exact interval lengths, the tick gating, and the fact that a write with no restart leaves a running count untouched. These depend on counting cycles between a write and a pulse.

// File: rtl/tbt_timer.sv
module tbt_timer #(
  parameter int BASE_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq_set,
  output logic       irq_clr
);

  localparam int LONGEST = BASE_TICKS * 128;
  localparam int CW = $clog2(LONGEST + 1);

  logic [7:0]    ctl_q;
  logic          ovf_q;
  logic          run_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] span(input logic [1:0] sel);
    case (sel)
      2'd0:    span = CW'(BASE_TICKS);
      2'd1:    span = CW'(BASE_TICKS * 4);
      2'd2:    span = CW'(BASE_TICKS * 16);
      default: span = CW'(LONGEST);
    endcase
  endfunction

  logic restart, rate_chg, reload, expire, flag_clr;

  assign restart  = wr_en && !wr_data[2];
  assign rate_chg = wr_en && (wr_data[1:0] != ctl_q[1:0]);
  assign reload   = restart || rate_chg;
  assign expire   = run_q && tick_en && (cnt_q == CW'(1)) && !reload;
  assign flag_clr = wr_en && !wr_data[3] && ovf_q;

  assign rd_data = {ctl_q[7:4], ovf_q, ctl_q[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      ovf_q   <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
      irq_set <= 1'b0;
      irq_clr <= 1'b0;
    end else begin
      if (wr_en) ctl_q <= wr_data;
      if (expire)        ovf_q <= 1'b1;
      else if (flag_clr) ovf_q <= 1'b0;
      if (reload) begin
        run_q <= 1'b1;
        cnt_q <= span(wr_data[1:0]);
      end else if (expire) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (run_q && tick_en) begin
        cnt_q <= cnt_q - CW'(1);
      end
      irq_set <= expire && ctl_q[4];
      irq_clr <= restart || (flag_clr && !expire);
    end
  end

  p_set_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> ovf_q);

  p_set_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> $past(ctl_q[4]));

  p_stop_on_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> !run_q);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_q) && !$past(wr_en)) |-> !irq_set);

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !wr_data[2]) |-> (irq_clr && run_q));

  p_rate_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && ($past(wr_data[1:0]) != $past(ctl_q[1:0]))) |-> (run_q && !irq_set));

  p_no_sw_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(ovf_q) && !$past(expire)) |-> !ovf_q);

endmodule

// File: tb/tbt_timer_test.sv
module tbt_timer_test;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_set, irq_clr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  bit    q_kind[$];
  int    q_cyc[$];
  string q_req[$];

  tbt_timer #(.BASE_TICKS(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_set(irq_set), .irq_clr(irq_clr)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_ev(bit is_set, int at, string req);
    q_kind.push_back(is_set);
    q_cyc.push_back(at);
    q_req.push_back(req);
  endtask

  task automatic seen(bit is_set);
    bit k; int c; string r;
    checks++;
    if (q_kind.size() == 0) begin
      errors++;
      $display("FAIL unexpected pulse: actual %s at cycle %0d, expected none (R1/R8/R9)",
               is_set ? "set" : "clr", cyc);
      return;
    end
    k = q_kind.pop_front(); c = q_cyc.pop_front(); r = q_req.pop_front();
    if (k != is_set || c != cyc) begin
      errors++;
      $display("FAIL %s: actual %s at cycle %0d, expected %s at cycle %0d",
               r, is_set ? "set" : "clr", cyc, k ? "set" : "clr", c);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (irq_clr) seen(1'b0);
    if (irq_set) seen(1'b1);
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d, output int c0);
    c0 = cyc;
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0, c1;
    idle(4);
    rst_n = 1'b1;
    // R1 reset state, quiet
    chk("R1", rd_data, 8'h00);
    idle(20);
    chk("R1", rd_data, 8'h00);

    // R5 restart + R3 rate 0
    wr(8'h90, c0);
    expect_ev(0, c0 + 1, "R5");
    expect_ev(1, c0 + 1 + BASE, "R3");
    idle(BASE + 4);
    chk("R2", rd_data, 8'h98);
    idle(20); // R8 stays stopped

    // R10 clear flag, then software cannot set it
    wr(8'h94, c0);
    expect_ev(0, c0 + 1, "R10");
    chk("R10", rd_data, 8'h94);
    idle(3);
    wr(8'h9C, c0);
    chk("R10", rd_data, 8'h94);
    idle(10);

    // R6 rate change without restart, R3 rate 1
    wr(8'h95, c0);
    expect_ev(1, c0 + 1 + BASE * 4, "R6");
    idle(BASE * 4 + 4);
    chk("R3", rd_data, 8'h9D);

    // R7 neutral write during a rate-2 count
    wr(8'h92, c0);
    expect_ev(0, c0 + 1, "R5");
    expect_ev(1, c0 + 1 + BASE * 16, "R7");
    idle(20);
    wr(8'hB6, c1);
    chk("R2", rd_data, 8'hB6);
    idle(BASE * 16);
    chk("R3", rd_data, 8'hBE);

    // R9 masked expiry still sets the flag
    wr(8'h81, c0);
    expect_ev(0, c0 + 1, "R10");
    idle(BASE * 4 + 10);
    chk("R9", rd_data, 8'h89);

    // R4 tick gating
    wr(8'h90, c0);
    expect_ev(0, c0 + 1, "R10");
    expect_ev(1, c0 + 1 + BASE + 3, "R4");
    tick_en = 1'b0;
    idle(3);
    tick_en = 1'b1;
    idle(BASE + 4);
    chk("R4", rd_data, 8'h98);

    // R3 rate 3
    wr(8'h93, c0);
    expect_ev(0, c0 + 1, "R5");
    expect_ev(1, c0 + 1 + BASE * 128, "R3");
    idle(BASE * 128 + 8);
    chk("R8", rd_data, 8'h9B);

    // R5 restart during a count moves the expiry
    wr(8'h93, c0);
    expect_ev(0, c0 + 1, "R5");
    idle(200);
    wr(8'h9B, c1);
    expect_ev(0, c1 + 1, "R5");
    expect_ev(1, c1 + 1 + BASE * 128, "R5");
    idle(BASE * 128 + 8);
    chk("R5", rd_data, 8'h9B);
    idle(30);

    checks++;
    if (q_kind.size() != 0) begin
      errors++;
      $display("FAIL R3: actual %0d events still pending, expected 0", q_kind.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule